// File: doc/BRIEF.md
# Variable-Granularity Pattern Bank Mapper

This block translates the 8 KB video pattern-memory space into physical 1 KB bank numbers. Software programs eight low bank registers and eight high bank registers through two separate write windows, each indexed by a 3-bit register index, plus a control window holding a granularity selector and an outer-bank setting. The block then presents, for each of the eight 1 KB slots of pattern space, the physical 1 KB bank that a memory controller should fetch from. It also offers a direct lookup where the upper three pattern-address bits pick one slot.

Pages can be 8, 4, 2 or 1 KB wide. A page number is 16 bits, formed from a high/low register pair. An optional outer-bank mode confines the page number to a sub-region. The inner page is cut to a width that depends on the page size, and a 3-bit outer number is placed directly above it. Slot outputs are always expressed in 1 KB units, so a wider page spreads across several consecutive slots.

Top module: `pat_bank_mapper`

## Requirements
- R1: After reset every low and high bank register holds 0xFF and both control fields hold 0, so slot k reads 0xF8 + k.
- R2: A write takes effect on the rising clock edge where wr_en_i is high. Window code 0 writes low register wr_idx_i, code 1 writes high register wr_idx_i, code 2 writes a control register, and code 3 is ignored. No state changes while wr_en_i is low.
- R3: The 16-bit page number of pair p is the high register p in bits 15:8 and the low register p in bits 7:0.
- R4: Control register 0 bits 4:3 select the page size: 0 gives 8 KB, 1 gives 4 KB, 2 gives 2 KB and 3 gives 1 KB.
- R5: The pair that serves slot k is 0 for 8 KB, k&4 for 4 KB, k&6 for 2 KB and k for 1 KB.
- R6: A slot outputs the page number times the page size in KB, plus the slot's offset inside that page (k, k&3, k&1 or 0 for the four sizes).
- R7: When control register 3 bit 5 is 0, outer banking is active and the outer number is {bit 4, bit 3, bit 0} of control register 3.
- R8: With outer banking active, the page number is masked to 0x1F, 0x3F, 0x7F or 0xFF for 8, 4, 2 or 1 KB, and the outer number shifted left by 5, 6, 7 or 8 is ORed in.
- R9: When control register 3 bit 5 is 1, the page number is used unmasked and no outer number is added.
- R10: The lookup output equals the slot output selected by addr_hi_i (pattern address bits 12:10).
- R11: In the control window only the index values 0 and 3 (wr_idx_i bits 1:0) hold state. Writes to indices 1 and 2 change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_win_i | input | 2 | Window: 0 low, 1 high, 2 control, 3 unused |
| wr_idx_i | input | 3 | Register index inside the window |
| wr_data_i | input | 8 | Write data |
| addr_hi_i | input | 3 | Pattern address bits 12:10 for the lookup |
| slot_bank_o | output | 152 | Eight 19-bit physical 1 KB banks, slot k at bits 19k+18:19k |
| addr_bank_o | output | 19 | Physical 1 KB bank of the slot picked by addr_hi_i |

## Verification
Every output is a combinational function of the registered state, so a corrupted bank register, granularity field or outer setting appears on the slot outputs in the cycle right after the write that caused it. A wrong pair choice or offset shows up as a slot that does not follow the spread pattern of its page size. A wrong mask or shift shows up in the upper bits of every slot. Each programmed state is therefore compared on all eight slots and through the lookup before the next write.

// File: rtl/pat_map_pkg.sv
package pat_map_pkg;
    localparam int REG_W      = 8;
    localparam int SLOTS      = 8;
    localparam int SLOT_IDX_W = $clog2(SLOTS);
    localparam int BANK_W     = 2 * REG_W;
    localparam int PHYS_W     = BANK_W + SLOT_IDX_W;
    localparam int OUTER_W    = 3;
    localparam int OUTER_BASE = 5;

    typedef enum logic [1:0] {
        GRAN_8K = 2'd0,
        GRAN_4K = 2'd1,
        GRAN_2K = 2'd2,
        GRAN_1K = 2'd3
    } gran_e;

    typedef enum logic [1:0] {
        WIN_LO  = 2'd0,
        WIN_HI  = 2'd1,
        WIN_CTL = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef struct packed {
        logic [SLOTS-1:0][REG_W-1:0] lo;
        logic [SLOTS-1:0][REG_W-1:0] hi;
        gran_e                       gran;
        logic                        outer_off;
        logic [OUTER_W-1:0]          outer_num;
    } map_state_t;
endpackage

// File: rtl/pat_bank_regs.sv
module pat_bank_regs
    import pat_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_win_i,
    input  logic [SLOT_IDX_W-1:0] wr_idx_i,
    input  logic [REG_W-1:0]      wr_data_i,
    output map_state_t            state_o
);
    localparam logic [1:0] CTL_GRAN_IDX  = 2'd0;
    localparam logic [1:0] CTL_OUTER_IDX = 2'd3;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (win_e'(wr_win_i))
                WIN_LO:  st_d.lo[wr_idx_i] = wr_data_i;
                WIN_HI:  st_d.hi[wr_idx_i] = wr_data_i;
                WIN_CTL: begin
                    case (wr_idx_i[1:0])
                        CTL_GRAN_IDX:  st_d.gran = gran_e'(wr_data_i[4:3]);
                        CTL_OUTER_IDX: begin
                            st_d.outer_off = wr_data_i[5];
                            st_d.outer_num = {wr_data_i[4:3], wr_data_i[0]};
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo        <= '1;
            st_q.hi        <= '1;
            st_q.gran      <= GRAN_8K;
            st_q.outer_off <= 1'b0;
            st_q.outer_num <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/pat_slot_xlat.sv
module pat_slot_xlat
    import pat_map_pkg::*;
#(
    parameter int SLOT_ID = 0
) (
    input  gran_e                       gran_i,
    input  logic                        outer_en_i,
    input  logic [OUTER_W-1:0]          outer_num_i,
    input  logic [SLOTS-1:0][REG_W-1:0] lo_i,
    input  logic [SLOTS-1:0][REG_W-1:0] hi_i,
    output logic [PHYS_W-1:0]           phys_o
);
    localparam logic [SLOT_IDX_W-1:0] K = SLOT_IDX_W'(SLOT_ID);

    logic [SLOT_IDX_W-1:0] pair;
    logic [SLOT_IDX_W-1:0] off;
    logic [BANK_W-1:0]     raw;
    logic [BANK_W-1:0]     mask;
    logic [BANK_W-1:0]     outer_sh;
    logic [BANK_W-1:0]     page;
    logic [1:0]            spread;

    always_comb begin
        case (gran_i)
            GRAN_8K: begin pair = '0;           off = K;            end
            GRAN_4K: begin pair = K & 3'b100;   off = K & 3'b011;   end
            GRAN_2K: begin pair = K & 3'b110;   off = K & 3'b001;   end
            default: begin pair = K;            off = '0;           end
        endcase
        raw      = {hi_i[pair], lo_i[pair]};
        mask     = (BANK_W'(1) << (OUTER_BASE + int'(gran_i))) - BANK_W'(1);
        outer_sh = BANK_W'(outer_num_i) << (OUTER_BASE + int'(gran_i));
        page     = outer_en_i ? ((raw & mask) | outer_sh) : raw;
        spread   = 2'd3 - gran_i;
        phys_o   = (PHYS_W'(page) << spread) | PHYS_W'(off);
    end
endmodule

// File: rtl/pat_bank_mapper.sv
module pat_bank_mapper
    import pat_map_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [1:0]                wr_win_i,
    input  logic [SLOT_IDX_W-1:0]     wr_idx_i,
    input  logic [REG_W-1:0]          wr_data_i,
    input  logic [SLOT_IDX_W-1:0]     addr_hi_i,
    output logic [SLOTS*PHYS_W-1:0]   slot_bank_o,
    output logic [PHYS_W-1:0]         addr_bank_o
);
    map_state_t                       regs_w;
    gran_e                            gran_w;
    logic                             outer_en_w;
    logic [OUTER_W-1:0]               outer_num_w;
    logic [SLOTS-1:0][PHYS_W-1:0]     slot_w;

    pat_bank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_win_i  (wr_win_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .state_o   (regs_w)
    );

    assign gran_w      = regs_w.gran;
    assign outer_en_w  = ~regs_w.outer_off;
    assign outer_num_w = regs_w.outer_num;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        pat_slot_xlat #(.SLOT_ID(k)) u_xlat (
            .gran_i      (gran_w),
            .outer_en_i  (outer_en_w),
            .outer_num_i (outer_num_w),
            .lo_i        (regs_w.lo),
            .hi_i        (regs_w.hi),
            .phys_o      (slot_w[k])
        );
        assign slot_bank_o[k*PHYS_W +: PHYS_W] = slot_w[k];
    end

    assign addr_bank_o = slot_w[addr_hi_i];
endmodule

// File: rtl/pat_bank_mapper_chk.sv
module pat_bank_mapper_chk
    import pat_map_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en_i,
    input logic [1:0]              wr_win_i,
    input logic [SLOT_IDX_W-1:0]   wr_idx_i,
    input logic [SLOTS*PHYS_W-1:0] slot_bank_o,
    input logic [PHYS_W-1:0]       addr_bank_o,
    input logic [SLOT_IDX_W-1:0]   addr_hi_i,
    input gran_e                   gran_w,
    input logic                    outer_en_w,
    input logic [OUTER_W-1:0]      outer_num_w
);
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(slot_bank_o)); // R2

    AST_DEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_win_i == 2'd3) |=> $stable(slot_bank_o)); // R2

    AST_CTL_UNUSED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_win_i == 2'd2 && (wr_idx_i[1:0] == 2'd1 || wr_idx_i[1:0] == 2'd2))
        |=> $stable(slot_bank_o)); // R11

    AST_LOOKUP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_bank_o == slot_bank_o[addr_hi_i*PHYS_W +: PHYS_W]); // R10

    AST_8K_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        gran_w == GRAN_8K |-> slot_bank_o[2:0] == 3'd0); // R6

    AST_1K_OUTER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gran_w == GRAN_1K && outer_en_w) |->
        slot_bank_o[PHYS_W-1:8] == (PHYS_W-8)'(outer_num_w)); // R8

    for (genvar k = 1; k < SLOTS; k++) begin : g_chk
        AST_8K_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
            gran_w == GRAN_8K |->
            slot_bank_o[k*PHYS_W +: PHYS_W] == slot_bank_o[PHYS_W-1:0] + PHYS_W'(k)); // R6
    end
endmodule

bind pat_bank_mapper pat_bank_mapper_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_win_i    (wr_win_i),
    .wr_idx_i    (wr_idx_i),
    .slot_bank_o (slot_bank_o),
    .addr_bank_o (addr_bank_o),
    .addr_hi_i   (addr_hi_i),
    .gran_w      (gran_w),
    .outer_en_w  (outer_en_w),
    .outer_num_w (outer_num_w)
);

// File: tb/pat_bank_mapper_bench.sv
`timescale 1ns/1ps
module pat_bank_mapper_bench;
    import pat_map_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    wr_en_i = 1'b0;
    logic [1:0]              wr_win_i = 2'd0;
    logic [SLOT_IDX_W-1:0]   wr_idx_i = '0;
    logic [REG_W-1:0]        wr_data_i = '0;
    logic [SLOT_IDX_W-1:0]   addr_hi_i = '0;
    logic [SLOTS*PHYS_W-1:0] slot_bank_o;
    logic [PHYS_W-1:0]       addr_bank_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_lo [8];
    logic [7:0] m_hi [8];
    logic [7:0] m_c0;
    logic [7:0] m_c3;

    always #2 clk = ~clk;

    pat_bank_mapper u_pat_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_win_i(wr_win_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .addr_hi_i(addr_hi_i),
        .slot_bank_o(slot_bank_o), .addr_bank_o(addr_bank_o)
    );

    function automatic logic [18:0] exp_slot(int k);
        int s;
        int pair;
        int off;
        logic [15:0] pg;
        logic [15:0] msk;
        logic [2:0]  outer;
        s = int'(m_c0[4:3]);
        case (s)
            0: begin pair = 0;     off = k;     end
            1: begin pair = k & 4; off = k & 3; end
            2: begin pair = k & 6; off = k & 1; end
            default: begin pair = k; off = 0;   end
        endcase
        pg = {m_hi[pair], m_lo[pair]};
        if (!m_c3[5]) begin
            outer = {m_c3[4], m_c3[3], m_c3[0]};
            msk = (16'h0020 << s) - 16'h1;
            pg = (pg & msk) | (16'(outer) << (5 + s));
        end
        return (19'(pg) << (3 - s)) | 19'(off);
    endfunction

    task automatic model_write(logic [1:0] w, logic [2:0] i, logic [7:0] d);
        case (w)
            2'd0: m_lo[i] = d;
            2'd1: m_hi[i] = d;
            2'd2: begin
                if (i[1:0] == 2'd0) m_c0 = d;
                else if (i[1:0] == 2'd3) m_c3 = d;
            end
            default: ;
        endcase
    endtask

    task automatic do_write(logic [1:0] w, logic [2:0] i, logic [7:0] d, bit en = 1);
        @(negedge clk);
        wr_en_i = en; wr_win_i = w; wr_idx_i = i; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (en) model_write(w, i, d);
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < SLOTS; k++) begin
            logic [18:0] e;
            e = exp_slot(k);
            addr_hi_i = 3'(k);
            #0.1;
            n_chk++;
            if (slot_bank_o[k*PHYS_W +: PHYS_W] !== e) begin
                n_bad++;
                $display("FAIL %s slot %0d actual %h expected %h", tag, k,
                         slot_bank_o[k*PHYS_W +: PHYS_W], e);
            end
            n_chk++;
            if (addr_bank_o !== e) begin
                n_bad++;
                $display("FAIL R10 (%s) lookup %0d actual %h expected %h", tag, k,
                         addr_bank_o, e);
            end
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 8; i++) begin m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; end
        m_c0 = 8'h00; m_c3 = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // raw mode, pairs with distinct values
        do_write(2'd2, 3'd3, 8'h20);
        for (int i = 0; i < 8; i++) begin
            do_write(2'd0, 3'(i), 8'(8'h10 + i));
            do_write(2'd1, 3'(i), 8'(8'h01 + i));
        end
        check_all("R3 R9 raw 8K");
        for (int g = 0; g < 4; g++) begin
            do_write(2'd2, 3'd0, 8'(g << 3));
            check_all("R4 R5 R6 size");
        end

        // outer banking active, outer = 7
        do_write(2'd2, 3'd3, 8'h19);
        for (int g = 0; g < 4; g++) begin
            do_write(2'd2, 3'd0, 8'(g << 3));
            check_all("R7 R8 outer");
        end
        do_write(2'd2, 3'd3, 8'h08);
        check_all("R7 outer bit3 only");

        // ignored writes
        do_write(2'd0, 3'd0, 8'h55, 0);
        check_all("R2 strobe low");
        do_write(2'd3, 3'd0, 8'hAA);
        check_all("R2 window 3");
        do_write(2'd2, 3'd1, 8'h38);
        check_all("R11 ctl idx1");
        do_write(2'd2, 3'd2, 8'h20);
        check_all("R11 ctl idx2");
        do_write(2'd2, 3'd4, 8'h18);
        check_all("R11 ctl idx4 aliases 0");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0] w;
            w = 2'($urandom_range(0, 3));
            do_write(w, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
                     bit'($urandom_range(0, 7) != 0));
            check_all("R2 R5 R6 R8 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule